// File: doc/BRIEF.md
# Timer Tick Clock Tree

This block turns one peripheral clock into five single-cycle tick enables, one per timer channel. There are two shared 8-bit prescalers. One serves channels 0 and 1, the other serves channels 2, 3 and 4. Each prescaler fires once every (value + 1) clock cycles.

Each channel has its own 4-bit select field. The field either divides its group's prescaled tick by a power of two (2, 4, 8 or 16) or routes an external timer clock to the channel. Channels 0 and 1 share external clock 0 and channels 2 to 4 share external clock 1. Each external clock passes through a two-flop synchronizer. A small edge state machine then turns every rising edge into one tick. The state machine has two states. EXT_LOW moves to EXT_HIGH when the synchronized level reads 1 and emits the tick on that transition. EXT_HIGH returns to EXT_LOW when the level reads 0.

Software programs the tree through a small register bus with a write strobe, an address and write data. Reads are combinational. Prescaler and divider changes are retimed so that no channel ever sees a shortened tick interval.

Top module: `tmr_clk_tree`

## Requirements
- R1: Address 0 holds prescaler 0 in bits [7:0] and prescaler 1 in bits [15:8]. Address 1 holds channel n's select field in bits [4n+3:4n]. Reads return the stored bits, with every unused bit read as 0. A write to address 2 or 3 changes nothing, and reads of those addresses return 0.
- R2: After reset, both prescalers are 0 and all select fields are 0. Every channel therefore ticks once every 2 cycles.
- R3: A prescaler holding value p produces a group tick once every p+1 cycles.
- R4: A select field with bit 2 clear divides the group tick by 2^(f+1), where f = bits [1:0]. The channel tick interval is therefore (p+1)·2^(f+1) cycles.
- R5: Channels 0 and 1 take their group tick from prescaler 0. Channels 2, 3 and 4 take theirs from prescaler 1.
- R6: A select field with bit 2 set routes the external clock to the channel and ignores the divided tick. Channels 0 and 1 use external clock 0 and channels 2 to 4 use external clock 1. Bit 3 has no effect.
- R7: Each rising edge of an external clock produces exactly one tick, one cycle wide. A level held high produces no further ticks.
- R8: A new prescaler value takes effect at the group's next prescaler wrap. The interval already under way finishes with the old value.
- R9: A new divider code takes effect at the channel's next output tick. Two divided ticks are never in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ext_clk_i | input | 2 | External timer clocks, one per group |
| tick_o | output | 5 | One-cycle tick enable per channel |

## Verification
The bench sweeps prescaler values and all four divider codes across every channel, giving the two groups different prescalers. A design that wired a channel to the wrong group, or that used a divisor off by one power of two, would show a wrong tick interval. Mid-interval writes to a prescaler and to a divider must yield one transitional interval of exactly 13 cycles and 16 cycles respectively. A design that reloaded immediately would produce a short or stretched interval there. Enough external-clock edges are counted to catch missed or doubled pulses, a held-high level that re-fires, a divided tick that leaks through while the external clock is idle, and bit 3 of a select field being wrongly decoded.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // number of prescaler groups, which is also the number of external clocks
    localparam int GRP_COUNT    = 2;
    // select-field bits that pick the power-of-two divider
    localparam int DIV_SEL_W    = 2;
    localparam int REG_PRESCALE = 0;
    localparam int REG_SELECT   = 1;

    typedef enum logic {
        EXT_LOW  = 1'b0,
        EXT_HIGH = 1'b1
    } ext_state_t;

    // channels below the split use group 0, the rest use group 1
    function automatic int grp_of(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int NUM_GRP = 2,
    parameter int PRE_W   = 8,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_GRP*PRE_W-1:0] pre_q,
    output logic [NUM_CH*SEL_W-1:0]  sel_q
);
    localparam int PRE_BITS = NUM_GRP * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;
    localparam int USED     = (PRE_BITS > SEL_BITS) ? PRE_BITS : SEL_BITS;

    logic hit_pre, hit_sel;
    assign hit_pre = bus_wr && (bus_addr == ADDR_W'(REG_PRESCALE));
    assign hit_sel = bus_wr && (bus_addr == ADDR_W'(REG_SELECT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sel_q <= '0;
        end else begin
            if (hit_pre) pre_q <= bus_wdata[PRE_BITS-1:0];
            if (hit_sel) sel_q <= bus_wdata[SEL_BITS-1:0];
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(REG_PRESCALE): bus_rdata = {{(DATA_W-PRE_BITS){1'b0}}, pre_q};
            ADDR_W'(REG_SELECT):   bus_rdata = {{(DATA_W-SEL_BITS){1'b0}}, sel_q};
            default:               bus_rdata = '0;
        endcase
    end

    generate
        if (USED < DATA_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^bus_wdata[DATA_W-1:USED];
        end
    endgenerate

    // R1: a prescaler write lands in the stored field
    p_wr_pre_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pre |=> pre_q == $past(bus_wdata[PRE_BITS-1:0]));
    // R1: writes to other addresses leave both registers untouched
    p_bad_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_pre && !hit_sel) |=> ($stable(pre_q) && $stable(sel_q)));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] preset,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    // the counter reloads only when it wraps, so a new preset waits for that point
    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= preset;
        else           cnt_q <= cnt_q - 1'b1;
    end

    // R8: the wrap reloads the preset that was present at the wrap
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == $past(preset));
    // R3: between wraps the counter steps down by one
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic tick
);
    logic       meta_q, lvl_q;
    ext_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            meta_q <= ext_i;
            lvl_q  <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_LOW:  if (lvl_q)  state_d = EXT_HIGH;
            EXT_HIGH: if (!lvl_q) state_d = EXT_LOW;
            default:              state_d = EXT_LOW;
        endcase
    end

    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            EXT_LOW:  tick = lvl_q;
            EXT_HIGH: tick = 1'b0;
            default:  tick = 1'b0;
        endcase
    end

    // R7: one pulse per edge, never two cycles wide
    p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R7: after a pulse the detector is armed high
    p_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> state_q == EXT_HIGH);
endmodule

// File: rtl/tmr_chan_div.sv
module tmr_chan_div
    import tmr_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic             ext_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W   = 1 << DIV_SEL_W;
    localparam int EXT_BIT = DIV_SEL_W;

    logic [DIV_SEL_W-1:0] af_q;
    logic [CNT_W-1:0]     dcnt_q;
    logic [CNT_W:0]       span, span_m1;
    logic                 hit;

    always_comb begin
        span    = (CNT_W+1)'(2) << af_q;
        span_m1 = span - (CNT_W+1)'(1);
    end

    assign hit = pre_tick && (dcnt_q == span_m1[CNT_W-1:0]);

    // the divider code is adopted only when a divided tick completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af_q   <= '0;
            dcnt_q <= '0;
        end else if (pre_tick) begin
            if (hit) begin
                dcnt_q <= '0;
                af_q   <= sel[DIV_SEL_W-1:0];
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    assign tick = sel[EXT_BIT] ? ext_tick : hit;

    logic unused_sel;
    assign unused_sel = span_m1[CNT_W] ^ (^sel[SEL_W-1:EXT_BIT+1]);

    // R9: divided ticks are never adjacent
    p_min_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sel[EXT_BIT]) |=> (sel[EXT_BIT] || !tick));
    // R4: a completed divided tick restarts the count
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> dcnt_q == '0);
endmodule

// File: rtl/tmr_clk_tree.sv
module tmr_clk_tree
    import tmr_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int GRP_SPLIT = 2,
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [GRP_COUNT-1:0] ext_clk_i,
    output logic [NUM_CH-1:0]    tick_o
);
    localparam int NUM_GRP = GRP_COUNT;

    logic [NUM_GRP*PRE_W-1:0] pre_q;
    logic [NUM_CH*SEL_W-1:0]  sel_q;
    logic [NUM_GRP-1:0]       grp_tick;
    logic [NUM_GRP-1:0]       ext_tick;

    tmr_regs #(
        .NUM_CH (NUM_CH),
        .NUM_GRP(NUM_GRP),
        .PRE_W  (PRE_W),
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pre_q    (pre_q),
        .sel_q    (sel_q)
    );

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
                .clk   (clk),
                .rst_n (rst_n),
                .preset(pre_q[g*PRE_W +: PRE_W]),
                .tick  (grp_tick[g])
            );
            tmr_ext_sync u_ext (
                .clk  (clk),
                .rst_n(rst_n),
                .ext_i(ext_clk_i[g]),
                .tick (ext_tick[g])
            );
        end
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            localparam int G = grp_of(n, GRP_SPLIT);
            tmr_chan_div #(.SEL_W(SEL_W)) u_div (
                .clk     (clk),
                .rst_n   (rst_n),
                .pre_tick(grp_tick[G]),
                .ext_tick(ext_tick[G]),
                .sel     (sel_q[n*SEL_W +: SEL_W]),
                .tick    (tick_o[n])
            );
        end
    endgenerate
endmodule

// File: tb/tb_tmr_clk_tree.sv
`timescale 1ns/1ps
module tb_tmr_clk_tree;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ext_clk = '0;
    logic [4:0]  tick_o;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    int     tick_cnt [5];
    int     doubles = 0;
    logic [4:0] prev_tick = '0;

    tmr_clk_tree dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ext_clk_i(ext_clk),
        .tick_o   (tick_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial for (int i = 0; i < 5; i++) tick_cnt[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 5; i++) begin
                if (tick_o[i]) tick_cnt[i] = tick_cnt[i] + 1;
                if (tick_o[i] && prev_tick[i]) doubles = doubles + 1;
            end
            prev_tick = tick_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_tick(input int ch, output longint t);
        int n = 0;
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (tick_o[ch]) begin
                t = cyc; done = 1;
            end else if (n > 3000) begin
                chk(0, "R4 tick timeout", ch, -1);
                t = cyc; done = 1;
            end
        end
    endtask

    // R3 R4 R5: check two settled intervals on one channel
    task automatic measure(input int ch, input longint exp, input string tag);
        longint t0, t1, t2;
        wait_tick(ch, t0);
        wait_tick(ch, t0);
        wait_tick(ch, t1);
        wait_tick(ch, t2);
        chk((t1 - t0) == exp, tag, t1 - t0, exp);
        chk((t2 - t1) == exp, tag, t2 - t1, exp);
    endtask

    task automatic run_sweep();
        int p0, p1, pg, fn;
        logic [31:0] fields;
        for (int pi = 0; pi < 3; pi++) begin
            p0 = (pi == 0) ? 0 : ((pi == 1) ? 2 : 6);
            p1 = 6 - p0;
            for (int f = 0; f < 4; f++) begin
                fields = '0;
                for (int n = 0; n < 5; n++) fields[4*n +: 4] = 4'((f + n) % 4);
                bus_write(2'd0, {16'h0, 8'(p1), 8'(p0)});
                bus_write(2'd1, fields);
                for (int n = 0; n < 5; n++) begin
                    pg = (n < 2) ? p0 : p1;
                    fn = (f + n) % 4;
                    measure(n, longint'((pg + 1) << (fn + 1)), "R3 R4 R5 interval");
                end
            end
        end
    endtask

    task automatic snap(output int s [5]);
        @(negedge clk);
        #1;
        for (int i = 0; i < 5; i++) s[i] = tick_cnt[i];
    endtask

    task automatic pulse_ext(input int g, input int cnt, input int hi, input int lo);
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk); ext_clk[g] = 1'b1;
            repeat (hi) @(negedge clk);
            ext_clk[g] = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        longint t0, t1, t2;
        int s0 [5];
        int s1 [5];

        repeat (5) @(negedge clk);
        bus_read(2'd0, rd); chk(rd == 32'h0, "R2 reset prescale reg", rd, 0);
        bus_read(2'd1, rd); chk(rd == 32'h0, "R2 reset select reg", rd, 0);
        @(negedge clk); rst_n = 1'b1;
        measure(0, 2, "R2 reset interval ch0");
        measure(4, 2, "R2 reset interval ch4");

        // R1: register map and readback
        bus_write(2'd0, 32'hFFFF_A5C3);
        bus_read(2'd0, rd); chk(rd == 32'h0000_A5C3, "R1 prescale readback", rd, 32'h0000_A5C3);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, rd); chk(rd == 32'h000F_FFFF, "R1 select readback", rd, 32'h000F_FFFF);
        bus_write(2'd2, 32'h0000_1234);
        bus_write(2'd3, 32'h0000_0000);
        bus_read(2'd0, rd); chk(rd == 32'h0000_A5C3, "R1 prescale kept", rd, 32'h0000_A5C3);
        bus_read(2'd1, rd); chk(rd == 32'h000F_FFFF, "R1 select kept", rd, 32'h000F_FFFF);
        bus_read(2'd2, rd); chk(rd == 32'h0, "R1 addr2 reads zero", rd, 0);
        bus_read(2'd3, rd); chk(rd == 32'h0, "R1 addr3 reads zero", rd, 0);
        bus_write(2'd1, 32'h0);
        bus_write(2'd0, 32'h0);

        run_sweep();

        // R8: prescaler change mid interval
        bus_write(2'd1, 32'h0);
        bus_write(2'd0, 32'h0000_0009);
        wait_tick(0, t0); wait_tick(0, t0); wait_tick(0, t0);
        repeat (2) @(negedge clk);
        bus_write(2'd0, 32'h0000_0002);
        wait_tick(0, t1);
        wait_tick(0, t2);
        chk((t1 - t0) == 13, "R8 transitional interval", t1 - t0, 13);
        chk((t2 - t1) == 6, "R8 new interval", t2 - t1, 6);

        // R9: divider change mid interval
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, 32'h0000_0003);
        wait_tick(0, t0); wait_tick(0, t0); wait_tick(0, t0);
        repeat (2) @(negedge clk);
        bus_write(2'd1, 32'h0);
        wait_tick(0, t1);
        wait_tick(0, t2);
        chk((t1 - t0) == 16, "R9 transitional interval", t1 - t0, 16);
        chk((t2 - t1) == 2, "R9 new interval", t2 - t1, 2);

        // R6: external routing, bit 3 ignored on ch3, divided tick ignored
        bus_write(2'd1, 32'h0004_C004);
        repeat (10) @(negedge clk);
        snap(s0);
        repeat (100) @(negedge clk);
        snap(s1);
        chk(s1[0] == s0[0], "R6 ch0 idle ext", s1[0] - s0[0], 0);
        chk(s1[3] == s0[3], "R6 ch3 idle ext", s1[3] - s0[3], 0);
        chk(s1[4] == s0[4], "R6 ch4 idle ext", s1[4] - s0[4], 0);
        chk((s1[1] - s0[1]) >= 49, "R6 ch1 still divided", s1[1] - s0[1], 50);

        snap(s0);
        pulse_ext(0, 10, 4, 4);
        pulse_ext(1, 6, 3, 5);
        repeat (6) @(negedge clk);
        snap(s1);
        chk((s1[0] - s0[0]) == 10, "R6 R7 ch0 ext edges", s1[0] - s0[0], 10);
        chk((s1[3] - s0[3]) == 6, "R6 R7 ch3 ext edges", s1[3] - s0[3], 6);
        chk((s1[4] - s0[4]) == 6, "R6 R7 ch4 ext edges", s1[4] - s0[4], 6);

        // R7: held level gives a single tick
        snap(s0);
        @(negedge clk); ext_clk[0] = 1'b1;
        repeat (50) @(negedge clk);
        snap(s1);
        chk((s1[0] - s0[0]) == 1, "R7 held high", s1[0] - s0[0], 1);
        ext_clk[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(doubles == 0, "R7 R9 no adjacent ticks", doubles, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule